// File: doc/BRIEF.md
# Synchronous Bus Cycle Controller with Wait States

This block is the master side of a clocked system bus. A client hands it one transfer at a time: a word address, four active-low byte-lane enables, a direction flag, an address-space flag (memory or I/O) and, for writes, the data word. The controller runs the transfer as a bus cycle on the same clock that the slave uses. It opens the cycle with a one-clock active-low address strobe and shows the space and direction indicators. It then waits, one whole clock at a time, until the slave pulls its active-low ready line. At that point it closes the cycle, returns the read word and raises a one-clock done pulse.

Each cycle lasts at least two clocks: the strobe clock and one data clock. Every clock in which ready is sampled inactive adds one wait state. An optional watchdog ends a cycle that has gone unanswered for a set number of samples. It flags that cycle as failed, so a missing slave cannot hang the client.

Top module: `sbus_master`

## Requirements
- R1: After reset, bus_strobe_n is 1, bus_doe is 0, done is 0, err is 0 and req_ready is 1.
- R2: When req_valid is 1 while req_ready is 1 at a rising edge, the next clock is the strobe clock: bus_strobe_n is 0 for exactly that one clock and returns to 1 for the rest of the cycle.
- R3: From the strobe clock through the last clock of the cycle, bus_addr, bus_lane_n and bus_wr_rd carry the accepted request's values and stay unchanged. bus_mem_io is 1 for a memory request (req_io = 0) and 0 for an I/O request (req_io = 1).
- R4: bus_ready_n is sampled at the rising edge that ends each clock after the strobe clock. A sample of 0 completes the cycle. Each sample of 1 adds one wait state, so a cycle with W wait states lasts 2+W clocks.
- R5: For a write, bus_doe is 1 and bus_dout equals the request's write data in every clock after the strobe clock up to and including the last clock. bus_doe is 0 in the strobe clock, in every clock of a read and while idle.
- R6: For a read, rdata takes the value of bus_din at the completing edge. rdata keeps its value across write cycles and across cycles that end by timeout.
- R7: done is 1 for exactly the one clock after the completing edge. req_ready is 1 only while no cycle is in progress, including the done clock. A req_valid raised during a cycle starts nothing.
- R8: With the timeout enabled, a cycle whose ready samples stay 1 for TMO_LIMIT consecutive samples ends at the edge of the last of those samples. done and err are then both 1 for one clock, and err is never 1 without done.
- R9: A cycle with TMO_LIMIT-1 wait states completes normally, with err at 0.
- R10: The level of bus_ready_n during the strobe clock has no effect on the cycle length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Client presents a transfer |
| req_addr | input | ADDR_W | Word address (byte address bits 31..2) |
| req_lane_n | input | LANES | Active-low byte-lane enables |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = I/O space, 0 = memory space |
| req_wdata | input | DATA_W | Write data |
| req_ready | output | 1 | Controller idle; a request is taken |
| bus_addr | output | ADDR_W | Bus word address |
| bus_lane_n | output | LANES | Bus byte-lane enables, active low |
| bus_strobe_n | output | 1 | Address strobe, active low |
| bus_mem_io | output | 1 | 1 = memory cycle, 0 = I/O cycle |
| bus_wr_rd | output | 1 | 1 = write cycle, 0 = read cycle |
| bus_dout | output | DATA_W | Data driven toward the slave |
| bus_doe | output | 1 | Output enable for bus_dout |
| bus_din | input | DATA_W | Data returned by the slave |
| bus_ready_n | input | 1 | Slave ready, active low |
| done | output | 1 | One-clock completion pulse |
| err | output | 1 | Cycle ended by timeout (with done) |
| rdata | output | DATA_W | Last word read |

## Verification
The hardest case to reach is the boundary between a slow slave and a dead one. One cycle has to end exactly on its final permitted ready sample with ready active. Another has to run one sample further with ready held inactive. The bench gets there by steering bus_ready_n clock by clock from a wait count. It sets the count to TMO_LIMIT-1 for one run and to far beyond the limit for the other, and it counts clocks from the strobe to done. It also holds ready active during the strobe clock and raises a second request in the middle of a wait. Both probe stimuli that must leave the cycle untouched.

// File: rtl/sbus_pkg.sv
package sbus_pkg;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_ADDR = 2'd1,
      PH_WAIT = 2'd2
   } phase_t;

endpackage

// File: rtl/sbus_req_hold.sv
module sbus_req_hold #(
   parameter int ADDR_W = 30,
   parameter int LANES  = 4,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] in_addr,
   input  logic [LANES-1:0]  in_lane_n,
   input  logic              in_write,
   input  logic              in_io,
   input  logic [DATA_W-1:0] in_wdata,
   output logic [ADDR_W-1:0] hold_addr,
   output logic [LANES-1:0]  hold_lane_n,
   output logic              hold_write,
   output logic              hold_io,
   output logic [DATA_W-1:0] hold_wdata
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold_addr   <= '0;
         hold_lane_n <= '1;
         hold_write  <= 1'b0;
         hold_io     <= 1'b0;
         hold_wdata  <= '0;
      end else if (load) begin
         hold_addr   <= in_addr;
         hold_lane_n <= in_lane_n;
         hold_write  <= in_write;
         hold_io     <= in_io;
         hold_wdata  <= in_wdata;
      end
   end

endmodule

// File: rtl/sbus_wait_timer.sv
module sbus_wait_timer #(
   parameter bit TMO_EN    = 1'b1,
   parameter int TMO_LIMIT = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic in_wait,
   input  logic ready_n,
   output logic expire
);

   localparam int TMO_W = (TMO_LIMIT < 2) ? 1 : $clog2(TMO_LIMIT);

   generate
      if (TMO_EN) begin : g_timer
         logic [TMO_W-1:0] miss_cnt;
         logic             last_miss;

         assign last_miss = (miss_cnt == TMO_W'(TMO_LIMIT - 1));
         assign expire    = in_wait & ready_n & last_miss;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               miss_cnt <= '0;
            end else if (in_wait && ready_n && !last_miss) begin
               miss_cnt <= miss_cnt + 1'b1;
            end else begin
               miss_cnt <= '0;
            end
         end

         AST_WAIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
            !in_wait |=> (miss_cnt == '0)); // R8
      end else begin : g_no_timer
         assign expire = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/sbus_phase_fsm.sv
module sbus_phase_fsm
   import sbus_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   start,
   input  logic   ready_n,
   input  logic   expire,
   output phase_t phase,
   output logic   ok_finish,
   output logic   done_q,
   output logic   err_q
);

   phase_t phase_nx;
   logic   any_finish;

   assign ok_finish  = (phase == PH_WAIT) & ~ready_n;
   assign any_finish = ok_finish | ((phase == PH_WAIT) & expire);

   always_comb begin
      phase_nx = phase;
      unique case (phase)
         PH_IDLE: if (start)      phase_nx = PH_ADDR;
         PH_ADDR:                 phase_nx = PH_WAIT;
         PH_WAIT: if (any_finish) phase_nx = PH_IDLE;
         default:                 phase_nx = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase  <= PH_IDLE;
         done_q <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         phase  <= phase_nx;
         done_q <= any_finish;
         err_q  <= any_finish & ~ok_finish;
      end
   end

   AST_ADDR_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_ADDR) |=> (phase == PH_WAIT)); // R2
   AST_START_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_ADDR) |-> ($past(phase) == PH_IDLE)); // R7
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q); // R7
   AST_ERR_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      err_q |-> done_q); // R8

endmodule

// File: rtl/sbus_data_lane.sv
module sbus_data_lane #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_wait,
   input  logic              is_write,
   input  logic              capture,
   input  logic [DATA_W-1:0] wdata,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout,
   output logic              doe,
   output logic [DATA_W-1:0] rdata
);

   assign doe  = in_wait & is_write;
   assign dout = wdata;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdata <= '0;
      end else if (capture) begin
         rdata <= din;
      end
   end

   AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!capture) |=> $stable(rdata)); // R6

endmodule

// File: rtl/sbus_master.sv
module sbus_master
   import sbus_pkg::*;
#(
   parameter int ADDR_W    = 30,
   parameter int DATA_W    = 32,
   parameter bit TMO_EN    = 1'b1,
   parameter int TMO_LIMIT = 8,
   localparam int LANES    = DATA_W / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [LANES-1:0]  req_lane_n,
   input  logic              req_write,
   input  logic              req_io,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              req_ready,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [LANES-1:0]  bus_lane_n,
   output logic              bus_strobe_n,
   output logic              bus_mem_io,
   output logic              bus_wr_rd,
   output logic [DATA_W-1:0] bus_dout,
   output logic              bus_doe,
   input  logic [DATA_W-1:0] bus_din,
   input  logic              bus_ready_n,
   output logic              done,
   output logic              err,
   output logic [DATA_W-1:0] rdata
);

   generate
      if (DATA_W < 8 || DATA_W % 8 != 0) begin : g_bad_data_w
         $error("sbus_master: DATA_W must be a positive multiple of 8");
      end
      if (ADDR_W < 1 || ADDR_W > 62) begin : g_bad_addr_w
         $error("sbus_master: ADDR_W out of range");
      end
      if (TMO_EN && TMO_LIMIT < 1) begin : g_bad_tmo
         $error("sbus_master: TMO_LIMIT must be at least 1");
      end
   endgenerate

   phase_t phase;
   logic   accept;
   logic   in_wait;
   logic   ok_finish;
   logic   expire;
   logic   hold_io;
   logic   hold_write;
   logic [DATA_W-1:0] hold_wdata;

   assign req_ready    = (phase == PH_IDLE);
   assign accept       = req_valid & req_ready;
   assign in_wait      = (phase == PH_WAIT);
   assign bus_strobe_n = (phase != PH_ADDR);
   assign bus_mem_io   = ~hold_io;
   assign bus_wr_rd    = hold_write;

   sbus_req_hold #(
      .ADDR_W (ADDR_W),
      .LANES  (LANES),
      .DATA_W (DATA_W)
   ) u_hold (
      .clk         (clk),
      .rst_n       (rst_n),
      .load        (accept),
      .in_addr     (req_addr),
      .in_lane_n   (req_lane_n),
      .in_write    (req_write),
      .in_io       (req_io),
      .in_wdata    (req_wdata),
      .hold_addr   (bus_addr),
      .hold_lane_n (bus_lane_n),
      .hold_write  (hold_write),
      .hold_io     (hold_io),
      .hold_wdata  (hold_wdata)
   );

   sbus_wait_timer #(
      .TMO_EN    (TMO_EN),
      .TMO_LIMIT (TMO_LIMIT)
   ) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .in_wait (in_wait),
      .ready_n (bus_ready_n),
      .expire  (expire)
   );

   sbus_phase_fsm u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (accept),
      .ready_n   (bus_ready_n),
      .expire    (expire),
      .phase     (phase),
      .ok_finish (ok_finish),
      .done_q    (done),
      .err_q     (err)
   );

   sbus_data_lane #(
      .DATA_W (DATA_W)
   ) u_data (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_wait  (in_wait),
      .is_write (hold_write),
      .capture  (ok_finish & ~hold_write),
      .wdata    (hold_wdata),
      .din      (bus_din),
      .dout     (bus_dout),
      .doe      (bus_doe),
      .rdata    (rdata)
   );

   AST_FIELDS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      in_wait |-> $stable({bus_addr, bus_lane_n, bus_wr_rd, bus_mem_io})); // R3
   AST_NO_DRIVE_IN_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_strobe_n |-> !bus_doe); // R5

endmodule

// File: tb/sbus_master_bench.sv
`timescale 1ns/1ps
module sbus_master_bench;

   localparam int AW  = 30;
   localparam int DW  = 32;
   localparam int LN  = DW / 8;
   localparam int TMO = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [LN-1:0] req_lane_n = '1;
   logic          req_write = 1'b0;
   logic          req_io = 1'b0;
   logic [DW-1:0] req_wdata = '0;
   logic          req_ready;
   logic [AW-1:0] bus_addr;
   logic [LN-1:0] bus_lane_n;
   logic          bus_strobe_n;
   logic          bus_mem_io;
   logic          bus_wr_rd;
   logic [DW-1:0] bus_dout;
   logic          bus_doe;
   logic [DW-1:0] bus_din = '0;
   logic          bus_ready_n = 1'b1;
   logic          done;
   logic          err;
   logic [DW-1:0] rdata;

   int total = 0;
   int bad   = 0;

   always #2.5 clk = ~clk;

   sbus_master #(
      .ADDR_W    (AW),
      .DATA_W    (DW),
      .TMO_EN    (1'b1),
      .TMO_LIMIT (TMO)
   ) u_sbus_master (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_valid    (req_valid),
      .req_addr     (req_addr),
      .req_lane_n   (req_lane_n),
      .req_write    (req_write),
      .req_io       (req_io),
      .req_wdata    (req_wdata),
      .req_ready    (req_ready),
      .bus_addr     (bus_addr),
      .bus_lane_n   (bus_lane_n),
      .bus_strobe_n (bus_strobe_n),
      .bus_mem_io   (bus_mem_io),
      .bus_wr_rd    (bus_wr_rd),
      .bus_dout     (bus_dout),
      .bus_doe      (bus_doe),
      .bus_din      (bus_din),
      .bus_ready_n  (bus_ready_n),
      .done         (done),
      .err          (err),
      .rdata        (rdata)
   );

   task automatic check(input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // One complete bus cycle driven and checked clock by clock.
   task automatic run_cycle(input logic wr, input logic io,
                            input logic [AW-1:0] addr, input logic [LN-1:0] lane,
                            input logic [DW-1:0] wd, input logic [DW-1:0] din,
                            input int waits, input bit rdy_in_strobe,
                            input bit poke_busy,
                            output int clocks, output logic got_err);
      int k;
      @(negedge clk);
      req_valid = 1'b1; req_addr = addr; req_lane_n = lane;
      req_write = wr; req_io = io; req_wdata = wd; bus_ready_n = 1'b1;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      check("R2", "strobe low in first clock", bus_strobe_n, 0);
      check("R3", "address", bus_addr, addr);
      check("R3", "lanes", bus_lane_n, lane);
      check("R3", "direction", bus_wr_rd, wr);
      check("R3", "space", bus_mem_io, !io);
      check("R5", "no drive in strobe clock", bus_doe, 0);
      check("R7", "busy during cycle", req_ready, 0);
      bus_ready_n = rdy_in_strobe ? 1'b0 : 1'b1;  // R10 probe
      k = 0;
      while (k < 64) begin
         @(posedge clk);
         @(negedge clk);
         if (done) break;
         check("R2", "strobe high after first clock", bus_strobe_n, 1);
         check("R3", "address held", bus_addr, addr);
         check("R3", "lanes held", bus_lane_n, lane);
         check("R5", "drive enable", bus_doe, wr);
         if (wr) check("R5", "write data", bus_dout, wd);
         check("R7", "busy in wait", req_ready, 0);
         if (poke_busy) begin
            if (k == 0) begin
               req_valid = 1'b1; req_addr = ~addr; req_write = !wr;
            end else begin
               req_valid = 1'b0;
            end
         end
         bus_din     = din;
         bus_ready_n = (k < waits) ? 1'b1 : 1'b0;
         k++;
      end
      clocks  = k + 1;
      got_err = err;
      check("R7", "idle in done clock", req_ready, 1);
      check("R5", "no drive after end", bus_doe, 0);
      bus_ready_n = 1'b1;
      bus_din = '0;
      @(negedge clk);
      check("R7", "done one clock", done, 0);
      check("R8", "err one clock", err, 0);
      check("R7", "no stray cycle", bus_strobe_n, 1);
   endtask

   task automatic t_reset();
      check("R1", "strobe", bus_strobe_n, 1);
      check("R1", "doe", bus_doe, 0);
      check("R1", "done", done, 0);
      check("R1", "err", err, 0);
      check("R1", "ready", req_ready, 1);
   endtask

   task automatic t_mem_read_fast();
      int c; logic e;
      run_cycle(1'b0, 1'b0, 30'h0123_4567, 4'b0000, 32'h0, 32'hCAFE_F00D,
                0, 1'b0, 1'b0, c, e);
      check("R4", "zero-wait length", c, 2);
      check("R6", "read word", rdata, 32'hCAFE_F00D);
      check("R8", "no error", e, 0);
   endtask

   task automatic t_io_write_waits();
      int c; logic e;
      run_cycle(1'b1, 1'b1, 30'h0000_0ABC, 4'b1100, 32'h1357_9BDF, 32'hFFFF_0000,
                3, 1'b0, 1'b0, c, e);
      check("R4", "three-wait length", c, 5);
      check("R6", "read word kept over write", rdata, 32'hCAFE_F00D);
   endtask

   task automatic t_ready_in_strobe();
      int c; logic e;
      run_cycle(1'b0, 1'b1, 30'h3FFF_FFFF, 4'b0111, 32'h0, 32'h2468_ACE0,
                2, 1'b1, 1'b0, c, e);
      check("R10", "ready in strobe clock ignored", c, 4);
      check("R6", "read word io", rdata, 32'h2468_ACE0);
   endtask

   task automatic t_busy_ignored();
      int c; logic e;
      run_cycle(1'b1, 1'b0, 30'h0055_AA00, 4'b1110, 32'hA5A5_5A5A, 32'h0,
                2, 1'b0, 1'b1, c, e);
      check("R7", "length with busy request", c, 4);
   endtask

   task automatic t_timeout();
      int c; logic e;
      run_cycle(1'b0, 1'b0, 30'h0000_1000, 4'b0000, 32'h0, 32'hDEAD_BEEF,
                1000, 1'b0, 1'b0, c, e);
      check("R8", "timeout length", c, 1 + TMO);
      check("R8", "error flag", e, 1);
      check("R6", "read word kept over timeout", rdata, 32'h2468_ACE0);
   endtask

   task automatic t_last_sample_ok();
      int c; logic e;
      run_cycle(1'b0, 1'b0, 30'h0000_2000, 4'b0000, 32'h0, 32'h0BAD_C0DE,
                TMO - 1, 1'b0, 1'b0, c, e);
      check("R9", "length at limit", c, 1 + TMO);
      check("R9", "no error at limit", e, 0);
      check("R9", "read word at limit", rdata, 32'h0BAD_C0DE);
   endtask

   bit finished = 1'b0;

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_mem_read_fast();
      t_io_write_waits();
      t_ready_in_strobe();
      t_busy_ignored();
      t_timeout();
      t_last_sample_ok();
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule